// File: doc/BRIEF.md
# Branch Target Address Generator

This block works out the next program counter for the branch instructions of an 8-bit microcontroller core. Each cycle that `in_valid` is high it takes the current instruction address, the instruction length in bytes, the opcode byte, up to two operand bytes, a branch-kind code and a taken flag. It returns the 16-bit address to fetch next, registered, one cycle later.

Five kinds are handled:
- **Sequential step.** The address of the next instruction.
- **Short relative jump.** A signed byte offset added to the address of the next instruction.
- **In-page absolute jump.** Three opcode bits and one operand byte are spliced into the low 11 bits of the next-instruction address.
- **Long absolute jump.** A full 16-bit destination taken from the two operand bytes.
- **Conditional relative branch.** Used for compare-not-equal, decrement-non-zero and bit tests.

The condition itself is evaluated elsewhere in the core and arrives as `cond_taken`. Stack handling for calls is not part of the block.

Top module: `bta_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, `out_valid` becomes 0 and `next_pc` becomes 0x0000.
- R2: `out_valid` equals `in_valid` of the previous cycle. When `in_valid` was 0, `next_pc` keeps its previous value.
- R3: With `br_kind` = 0 (sequential), `next_pc` = `cur_pc` + `insn_len`, where `insn_len` is 1, 2 or 3.
- R4: With `br_kind` = 1 (short relative), `next_pc` = `cur_pc` + `insn_len` + the offset byte read as a signed two's-complement value.
- R5: The relative offset byte is the last byte of the instruction. This is `opnd_b` when `insn_len` = 3 and `opnd_a` otherwise. The rule holds for kinds 1 and 4.
- R6: With `br_kind` = 2 (in-page absolute), `next_pc[15:11]` comes from `cur_pc` + `insn_len`, `next_pc[10:8]` = `opcode[7:5]` and `next_pc[7:0]` = `opnd_a`.
- R7: With `br_kind` = 3 (long absolute), `next_pc` = {`opnd_a`, `opnd_b`}, so `opnd_a` is the high byte.
- R8: With `br_kind` = 4 (conditional relative), `next_pc` is the relative target of R4/R5 when `cond_taken` = 1 and `cur_pc` + `insn_len` when `cond_taken` = 0.
- R9: `cond_taken` has no effect for kinds 0 to 3.
- R10: `br_kind` codes 5, 6 and 7 behave as the sequential step.
- R11: All address sums wrap modulo 65536.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| cur_pc | input | 16 | Address of the branch instruction |
| insn_len | input | 2 | Instruction length in bytes (1 to 3) |
| br_kind | input | 3 | Branch kind code (0 seq, 1 short rel, 2 in-page, 3 long, 4 cond rel) |
| cond_taken | input | 1 | Branch condition result for kind 4 |
| opcode | input | 8 | Opcode byte |
| opnd_a | input | 8 | First operand byte |
| opnd_b | input | 8 | Second operand byte |
| next_pc | output | 16 | Registered next fetch address |
| out_valid | output | 1 | `next_pc` holds a fresh result |

## Verification
The bench targets the following corner cases:
- **Offset sign.** A 0x80 offset must move backwards by 128. A design that zero-extends it jumps forwards instead.
- **Wrap-around.** Relative targets and the sequential step must wrap past 0xFFFF and below 0x0000.
- **In-page splice at a page boundary.** The instruction sits at the last byte of a 2 KB page, so the page bits must come from the incremented address. Using `cur_pc` would land one page too low.
- **Offset byte choice.** A three-byte conditional branch must take `opnd_b` as its offset. Choosing `opnd_a` there gives a wildly wrong target.
- **Ignored inputs.** The taken flag is varied on unconditional kinds, and unused kind codes are applied. Either would expose a design that gates jumps wrongly.

// File: rtl/bta_pkg.sv
package bta_pkg;
  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;
  localparam int LEN_W  = 2;
  localparam int PAGE_W = 11;
  localparam int KIND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    BK_SEQ   = 3'd0,
    BK_SREL  = 3'd1,
    BK_PAGE  = 3'd2,
    BK_LONG  = 3'd3,
    BK_COND  = 3'd4
  } br_kind_e;
endpackage

// File: rtl/bta_seq_add.sv
// Address of the instruction that follows: base plus length, wrapping.
module bta_seq_add #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 2
) (
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [LEN_W-1:0]  len_in,
  output logic [ADDR_W-1:0] pc_seq
);
  always_comb begin
    pc_seq = pc_in + ADDR_W'(len_in);
  end
endmodule

// File: rtl/bta_rel_add.sv
// Relative target: picks the offset byte at the end of the instruction,
// sign-extends it and adds it to the sequential address.
module bta_rel_add #(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8,
  parameter int LEN_W  = 2
) (
  input  logic [ADDR_W-1:0] base_pc,
  input  logic [LEN_W-1:0]  len_in,
  input  logic [BYTE_W-1:0] byte_a,
  input  logic [BYTE_W-1:0] byte_b,
  output logic [ADDR_W-1:0] rel_tgt
);
  localparam int EXT_W = ADDR_W - BYTE_W;
  localparam logic [LEN_W-1:0] LEN_THREE = LEN_W'(3);

  logic [BYTE_W-1:0] off_byte;
  logic [ADDR_W-1:0] off_ext;

  always_comb begin
    off_byte = (len_in == LEN_THREE) ? byte_b : byte_a;
    off_ext  = {{EXT_W{off_byte[BYTE_W-1]}}, off_byte};
    rel_tgt  = base_pc + off_ext;
  end
endmodule

// File: rtl/bta_abs_form.sv
// Absolute targets: the in-page splice and the full long destination.
module bta_abs_form #(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8,
  parameter int PAGE_W = 11
) (
  input  logic [ADDR_W-1:0] base_pc,
  input  logic [BYTE_W-1:0] op_byte,
  input  logic [BYTE_W-1:0] byte_a,
  input  logic [BYTE_W-1:0] byte_b,
  output logic [ADDR_W-1:0] page_tgt,
  output logic [ADDR_W-1:0] long_tgt
);
  localparam int OPB_W = PAGE_W - BYTE_W;

  always_comb begin
    page_tgt = {base_pc[ADDR_W-1:PAGE_W], op_byte[BYTE_W-1 -: OPB_W], byte_a};
    long_tgt = ADDR_W'({byte_a, byte_b});
  end
endmodule

// File: rtl/bta_gen.sv
// Branch target address generator, registered output.
module bta_gen
  import bta_pkg::*;
#(
  parameter int AW = bta_pkg::ADDR_W,
  parameter int BW = bta_pkg::BYTE_W,
  parameter int LW = bta_pkg::LEN_W,
  parameter int PW = bta_pkg::PAGE_W,
  parameter int KW = bta_pkg::KIND_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [AW-1:0] cur_pc,
  input  logic [LW-1:0] insn_len,
  input  logic [KW-1:0] br_kind,
  input  logic          cond_taken,
  input  logic [BW-1:0] opcode,
  input  logic [BW-1:0] opnd_a,
  input  logic [BW-1:0] opnd_b,
  output logic [AW-1:0] next_pc,
  output logic          out_valid
);
  logic [AW-1:0] seq_pc;
  logic [AW-1:0] rel_pc;
  logic [AW-1:0] page_pc;
  logic [AW-1:0] long_pc;
  logic [AW-1:0] pick_pc;

  bta_seq_add #(.ADDR_W(AW), .LEN_W(LW)) u_seq (
    .pc_in  (cur_pc),
    .len_in (insn_len),
    .pc_seq (seq_pc)
  );

  bta_rel_add #(.ADDR_W(AW), .BYTE_W(BW), .LEN_W(LW)) u_rel (
    .base_pc (seq_pc),
    .len_in  (insn_len),
    .byte_a  (opnd_a),
    .byte_b  (opnd_b),
    .rel_tgt (rel_pc)
  );

  bta_abs_form #(.ADDR_W(AW), .BYTE_W(BW), .PAGE_W(PW)) u_abs (
    .base_pc  (seq_pc),
    .op_byte  (opcode),
    .byte_a   (opnd_a),
    .byte_b   (opnd_b),
    .page_tgt (page_pc),
    .long_tgt (long_pc)
  );

  always_comb begin
    case (br_kind)
      KW'(BK_SREL): pick_pc = rel_pc;
      KW'(BK_PAGE): pick_pc = page_pc;
      KW'(BK_LONG): pick_pc = long_pc;
      KW'(BK_COND): pick_pc = cond_taken ? rel_pc : seq_pc;
      default:      pick_pc = seq_pc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      next_pc   <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) next_pc <= pick_pc;
    end
  end
endmodule

// File: rtl/bta_gen_chk.sv
module bta_gen_chk #(
  parameter int AW = 16,
  parameter int BW = 8,
  parameter int LW = 2,
  parameter int KW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [AW-1:0] cur_pc,
  input logic [LW-1:0] insn_len,
  input logic [KW-1:0] br_kind,
  input logic          cond_taken,
  input logic [BW-1:0] opcode,
  input logic [BW-1:0] opnd_a,
  input logic [BW-1:0] opnd_b,
  input logic [AW-1:0] next_pc,
  input logic          out_valid
);
  a_r2_valid_follow: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(next_pc)));

  a_r6_page_low: assert property (@(posedge clk) disable iff (rst)
    (in_valid && br_kind == KW'(2)) |=>
      (next_pc[10:0] == {$past(opcode[7:5]), $past(opnd_a)}));

  a_r7_long_load: assert property (@(posedge clk) disable iff (rst)
    (in_valid && br_kind == KW'(3)) |=>
      (next_pc == AW'({$past(opnd_a), $past(opnd_b)})));

  a_r8_not_taken: assert property (@(posedge clk) disable iff (rst)
    (in_valid && br_kind == KW'(4) && !cond_taken) |=>
      (next_pc == AW'($past(cur_pc) + AW'($past(insn_len)))));

  a_r10_spare_kind: assert property (@(posedge clk) disable iff (rst)
    (in_valid && br_kind >= KW'(5)) |=>
      (next_pc == AW'($past(cur_pc) + AW'($past(insn_len)))));
endmodule

bind bta_gen bta_gen_chk #(.AW(AW), .BW(BW), .LW(LW), .KW(KW)) u_bta_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .cur_pc     (cur_pc),
  .insn_len   (insn_len),
  .br_kind    (br_kind),
  .cond_taken (cond_taken),
  .opcode     (opcode),
  .opnd_a     (opnd_a),
  .opnd_b     (opnd_b),
  .next_pc    (next_pc),
  .out_valid  (out_valid)
);

// File: tb/bta_gen_bench.sv
module bta_gen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] cur_pc = '0;
  logic [1:0]  insn_len = 2'd1;
  logic [2:0]  br_kind = '0;
  logic        cond_taken = 1'b0;
  logic [7:0]  opcode = '0;
  logic [7:0]  opnd_a = '0;
  logic [7:0]  opnd_b = '0;
  logic [15:0] next_pc;
  logic        out_valid;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bta_gen u_bta_gen (
    .clk(clk), .rst(rst), .in_valid(in_valid), .cur_pc(cur_pc),
    .insn_len(insn_len), .br_kind(br_kind), .cond_taken(cond_taken),
    .opcode(opcode), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .next_pc(next_pc), .out_valid(out_valid)
  );

  // Fields: req[69:66] pc[65:50] len[49:48] kind[47:45] taken[44]
  //         op[43:36] a[35:28] b[27:20] pad[19:16] exp[15:0]
  localparam int NV = 17;
  localparam logic [69:0] VEC [NV] = '{
    {4'd3,  16'h1234, 2'd1, 3'd0, 1'b0, 8'h00, 8'h00, 8'h00, 4'h0, 16'h1235}, // R3
    {4'd11, 16'hFFFF, 2'd3, 3'd0, 1'b0, 8'h00, 8'h00, 8'h00, 4'h0, 16'h0002}, // R11 seq wrap
    {4'd4,  16'h0100, 2'd2, 3'd1, 1'b0, 8'h80, 8'h10, 8'h99, 4'h0, 16'h0112}, // R4 forward
    {4'd4,  16'h0100, 2'd2, 3'd1, 1'b1, 8'h80, 8'hFE, 8'h00, 4'h0, 16'h0100}, // R4 back
    {4'd11, 16'h0000, 2'd2, 3'd1, 1'b0, 8'h80, 8'h80, 8'h00, 4'h0, 16'hFF82}, // R11 under
    {4'd11, 16'hFFF0, 2'd2, 3'd1, 1'b0, 8'h80, 8'h7F, 8'h00, 4'h0, 16'h0071}, // R11 over
    {4'd6,  16'h3456, 2'd2, 3'd2, 1'b1, 8'hB1, 8'h22, 8'h00, 4'h0, 16'h3522}, // R6
    {4'd6,  16'h07FF, 2'd2, 3'd2, 1'b1, 8'h01, 8'h00, 8'h00, 4'h0, 16'h0800}, // R6 page edge
    {4'd9,  16'h0000, 2'd2, 3'd2, 1'b0, 8'hE1, 8'hFF, 8'h00, 4'h0, 16'h07FF}, // R9 page
    {4'd7,  16'h1000, 2'd3, 3'd3, 1'b1, 8'h02, 8'hAB, 8'hCD, 4'h0, 16'hABCD}, // R7
    {4'd9,  16'h1000, 2'd3, 3'd3, 1'b0, 8'h02, 8'h12, 8'h34, 4'h0, 16'h1234}, // R9 long
    {4'd8,  16'h2000, 2'd2, 3'd4, 1'b1, 8'h60, 8'h05, 8'h77, 4'h0, 16'h2007}, // R8 taken
    {4'd8,  16'h2000, 2'd2, 3'd4, 1'b0, 8'h60, 8'h05, 8'h77, 4'h0, 16'h2002}, // R8 not taken
    {4'd5,  16'h2000, 2'd3, 3'd4, 1'b1, 8'hB5, 8'h55, 8'hFB, 4'h0, 16'h1FFE}, // R5 third byte
    {4'd8,  16'h2000, 2'd3, 3'd4, 1'b0, 8'hB5, 8'h55, 8'hFB, 4'h0, 16'h2003}, // R8
    {4'd10, 16'h4000, 2'd3, 3'd5, 1'b1, 8'h02, 8'h12, 8'h34, 4'h0, 16'h4003}, // R10
    {4'd10, 16'h5000, 2'd1, 3'd7, 1'b1, 8'h02, 8'h12, 8'h34, 4'h0, 16'h5001}  // R10
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset next_pc", next_pc, 16'h0000);
    check("R1 reset out_valid", {15'd0, out_valid}, 16'h0001 & 16'h0000);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      {cur_pc, insn_len, br_kind, cond_taken, opcode, opnd_a, opnd_b} = VEC[i][65:20];
      in_valid = 1'b1;
      @(negedge clk);
      check($sformatf("R%0d vec%0d", VEC[i][69:66], i), next_pc, VEC[i][15:0]);
      check($sformatf("R2 valid vec%0d", i), {15'd0, out_valid}, 16'h0001);
    end
    // R2: idle cycle keeps the last result even with inputs changing
    in_valid = 1'b0;
    cur_pc = 16'h7777; br_kind = 3'd3; opnd_a = 8'h11; opnd_b = 8'h22;
    @(negedge clk);
    check("R2 idle out_valid", {15'd0, out_valid}, 16'h0000);
    check("R2 idle hold", next_pc, 16'h5001);
    // R5: two-byte conditional uses first operand even with second set
    in_valid = 1'b1; cur_pc = 16'h0300; insn_len = 2'd2; br_kind = 3'd4;
    cond_taken = 1'b1; opnd_a = 8'hF0; opnd_b = 8'h40;
    @(negedge clk);
    check("R5 two-byte offset", next_pc, 16'h02F2);
    // R1: reset mid-run clears output
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid reset next_pc", next_pc, 16'h0000);
    check("R1 mid reset out_valid", {15'd0, out_valid}, 16'h0000);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end
endmodule